// File: doc/BRIEF.md
# Colour Subcarrier Synthesiser and Chroma Modulator

This block produces the colour part of an analogue television signal in the digital domain. A 32-bit phase accumulator, stepped by a programmable tuning word once per sample at twice the pixel rate, generates the colour subcarrier. A programmable phase offset is added to the accumulator, and the top bits of the sum address a quarter-wave sine table. The accumulator restarts at every field boundary, so the subcarrier phase is the same in every field.

Filtered colour-difference samples (U and V) are multiplied by the sine and cosine of the subcarrier. The rounded sum of the two products is the chroma sample. During the burst window the active colour is replaced by a fixed reference burst: a single 180° phase in the 525-line mode, or ±135° alternating line by line in the alternating-phase mode. Separate enables remove the active colour and the burst.

Luma is delayed by one to three extra samples relative to chroma. It is then added to chroma, and the sum is clamped to the unsigned output range to give composite video. Luma, chroma and composite each leave the block as registered samples.

Top module: `chroma_mod_top`

## Requirements
- R1: While `rst` is high, and on the first edge after it, `luma_o`, `chroma_o` and `comp_o` are all zero.
- R2: Count samples k from the sample that carries `field_start` (k = 0). Sample k uses the phase word ((k·`freq_word` + `phase_ofs`) mod 2^32). The accumulator wraps modulo 2^32, so a tuning word of 2^28 repeats the subcarrier every 16 samples.
- R3: The table index n is the top 8 bits of the phase word. Sine(n) = round(255·sin(2π(n+0.5)/256)) and cosine(n) = sine((n+64) mod 256), each as 9-bit signed.
- R4: For a sample taken at edge t, `chroma_o` after edge t+2 is floor((U·sine + V·cosine + 128) / 256). U and V are 8-bit two's complement and the result is 9-bit signed.
- R5: When `color_en` is 0 and `burst_win` is 0, the chroma of that sample is 0, whatever U and V are.
- R6: When `burst_win` is 1, U, V and `color_en` are ignored. If `burst_en` is 0 the chroma is 0. Otherwise, with `pal_mode` = 0, the sample is modulated with U = −60 and V = 0.
- R7: A line-parity flag is computed for each sample. A sample with `field_start` forces the flag to 0; otherwise a sample with `line_start` inverts it. With `pal_mode` = 1, burst samples use U = −42 with V = +42 when the flag is 0 and V = −42 when it is 1.
- R8: After edge e, `luma_o` holds the `y_in` sampled at edge e−2−D. D is the value of `luma_dly` at edge e, with 0 treated as 1.
- R9: `comp_o` is the clamp of (`luma_o` + signed `chroma_o`) to the range 0..511, in the same output cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock (twice the pixel rate) |
| rst | input | 1 | Synchronous active-high reset |
| freq_word | input | 32 | Subcarrier tuning word added per sample |
| phase_ofs | input | 32 | Subcarrier phase offset |
| color_en | input | 1 | 1 passes active colour, 0 removes it |
| burst_en | input | 1 | 1 inserts burst in the window, 0 mutes it |
| pal_mode | input | 1 | 1 selects the alternating ±135° burst |
| luma_dly | input | 2 | Extra luma delay, 1..3 (0 acts as 1) |
| field_start | input | 1 | First sample of a field: restarts phase and parity |
| line_start | input | 1 | First sample of a line: inverts parity |
| burst_win | input | 1 | Sample lies in the burst window |
| u_in | input | 8 | U sample, two's complement |
| v_in | input | 8 | V sample, two's complement |
| y_in | input | 9 | Luma sample, unsigned |
| luma_o | output | 9 | Delayed luma |
| chroma_o | output | 9 | Chroma, two's complement |
| comp_o | output | 9 | Composite, unsigned, clamped |

## Verification
A field restart and a line start can fall on the same sample, and that sample can lie inside the burst window. The phase then has to restart at the offset while the parity flag is forced to 0 instead of being inverted. The bench provokes this in the alternating-phase mode by issuing `field_start` on a line start that opens a burst window, every few lines. Each chroma sample there is compared with an arithmetic model that applies the R2 phase restart and the R7 precedence together, so a wrong order shows up as a wrong burst sign or a phase mismatch.

// File: rtl/cm_pkg.sv
package cm_pkg;

    localparam int ACC_W    = 32;
    localparam int QIDX_W   = 6;
    localparam int UV_W     = 8;
    localparam int Y_W      = 9;
    localparam int SIN_W    = 9;
    localparam int CH_W     = SIN_W;
    localparam int DLY_W    = 2;
    localparam int MAX_DLY  = 3;
    localparam int SIN_AMP  = 2 ** (SIN_W - 1) - 1;
    localparam int RND_SH   = SIN_W - 1;
    localparam int PROD_W   = UV_W + SIN_W + 1;

    localparam int BURST_NTSC = 60;
    localparam int BURST_DIAG = 42;

    typedef logic signed [SIN_W-1:0] sin_t;
    typedef logic signed [UV_W-1:0]  uv_t;
    typedef logic signed [CH_W-1:0]  ch_t;

    typedef struct packed {
        sin_t s;
        sin_t c;
        uv_t  u;
        uv_t  v;
    } mod_stage_t;

    typedef enum logic [1:0] {
        SRC_ACTIVE = 2'd0,
        SRC_BURST  = 2'd1,
        SRC_MUTE   = 2'd2
    } src_e;

    function automatic int quarter_sine(input int k, input int qn, input int amp);
        real ang;
        ang = 6.283185307179586 * (real'(k) + 0.5) / real'(4 * qn);
        return $rtoi($floor(real'(amp) * $sin(ang) + 0.5));
    endfunction

    function automatic ch_t clamp_ch(input logic signed [PROD_W-1:0] x);
        if (x > PROD_W'(2 ** (CH_W - 1) - 1))
            return ch_t'(2 ** (CH_W - 1) - 1);
        else if (x < -PROD_W'(2 ** (CH_W - 1)))
            return ch_t'(-(2 ** (CH_W - 1)));
        else
            return x[CH_W-1:0];
    endfunction

endpackage

// File: rtl/cm_phase_acc.sv
module cm_phase_acc
    import cm_pkg::*;
#(
    parameter int AW  = ACC_W,
    parameter int PW  = QIDX_W + 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] freq_word,
    input  logic [AW-1:0] phase_ofs,
    input  logic          field_start,
    input  logic          line_start,
    output logic [PW-1:0] ph_idx,
    output logic          line_odd
);
    logic [AW-1:0]    acc_q;
    logic [AW-1:0]    base;
    logic [AW-PW-1:0] ph_unused_frac;
    logic             odd_q;

    always_comb begin
        base = field_start ? '0 : acc_q;
        {ph_idx, ph_unused_frac} = base + phase_ofs;
        if (field_start)
            line_odd = 1'b0;
        else if (line_start)
            line_odd = ~odd_q;
        else
            line_odd = odd_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            odd_q <= 1'b0;
        end else begin
            acc_q <= base + freq_word;
            odd_q <= line_odd;
        end
    end
endmodule

// File: rtl/cm_sincos.sv
module cm_sincos
    import cm_pkg::*;
#(
    parameter int QW = QIDX_W
) (
    input  logic [QW+1:0] ph_idx,
    output sin_t          sin_o,
    output sin_t          cos_o
);
    localparam int QN    = 2 ** QW;
    localparam int MAG_W = SIN_W - 1;

    logic [MAG_W-1:0] qtab [QN];

    for (genvar k = 0; k < QN; k++) begin : g_tab
        assign qtab[k] = MAG_W'(quarter_sine(k, QN, SIN_AMP));
    end

    logic [1:0]       q_s, q_c;
    logic [QW-1:0]    idx;
    logic [MAG_W-1:0] mag_s, mag_c;

    always_comb begin
        q_s   = ph_idx[QW+1:QW];
        q_c   = q_s + 2'd1;
        idx   = ph_idx[QW-1:0];
        mag_s = q_s[0] ? qtab[~idx] : qtab[idx];
        mag_c = q_c[0] ? qtab[~idx] : qtab[idx];
        sin_o = q_s[1] ? -sin_t'({1'b0, mag_s}) : sin_t'({1'b0, mag_s});
        cos_o = q_c[1] ? -sin_t'({1'b0, mag_c}) : sin_t'({1'b0, mag_c});
    end
endmodule

// File: rtl/cm_quad_mod.sv
module cm_quad_mod
    import cm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  sin_t sin_i,
    input  sin_t cos_i,
    input  uv_t  u_i,
    input  uv_t  v_i,
    input  logic burst_win,
    input  logic burst_en,
    input  logic color_en,
    input  logic pal_mode,
    input  logic line_odd,
    output ch_t  chroma_o
);
    src_e       src;
    mod_stage_t nxt, s1;
    logic signed [PROD_W-1:0] p_u, p_v, acc_sum, rounded;

    always_comb begin
        if (burst_win)
            src = burst_en ? SRC_BURST : SRC_MUTE;
        else
            src = color_en ? SRC_ACTIVE : SRC_MUTE;

        nxt.s = sin_i;
        nxt.c = cos_i;
        unique case (src)
            SRC_ACTIVE: begin
                nxt.u = u_i;
                nxt.v = v_i;
            end
            SRC_BURST: begin
                if (pal_mode) begin
                    nxt.u = uv_t'(-BURST_DIAG);
                    nxt.v = line_odd ? uv_t'(-BURST_DIAG) : uv_t'(BURST_DIAG);
                end else begin
                    nxt.u = uv_t'(-BURST_NTSC);
                    nxt.v = '0;
                end
            end
            default: begin
                nxt.u = '0;
                nxt.v = '0;
            end
        endcase
    end

    always_comb begin
        p_u     = PROD_W'(s1.u) * PROD_W'(s1.s);
        p_v     = PROD_W'(s1.v) * PROD_W'(s1.c);
        acc_sum = p_u + p_v;
        rounded = (acc_sum + PROD_W'(2 ** (RND_SH - 1))) >>> RND_SH;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1       <= '0;
            chroma_o <= '0;
        end else begin
            s1       <= nxt;
            chroma_o <= clamp_ch(rounded);
        end
    end
endmodule

// File: rtl/cm_luma_comp.sv
module cm_luma_comp
    import cm_pkg::*;
#(
    parameter int YW = Y_W,
    parameter int DW = DLY_W,
    parameter int MD = MAX_DLY
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [YW-1:0] y_in,
    input  logic [DW-1:0] luma_dly,
    input  ch_t           chroma_i,
    output logic [YW-1:0] luma_o,
    output ch_t           chroma_o,
    output logic [YW-1:0] comp_o
);
    localparam int DEPTH = MD + 2;
    localparam int SW    = YW + 2;

    logic [YW-1:0]        ydl [DEPTH];
    logic [DW-1:0]        dsel;
    logic [YW-1:0]        luma_nxt;
    logic signed [SW-1:0] csum;
    logic [YW-1:0]        comp_nxt;

    always_comb begin
        dsel     = (luma_dly == '0) ? DW'(1) : luma_dly;
        luma_nxt = ydl[int'(dsel) + 1];
        csum     = $signed({2'b00, luma_nxt})
                 + $signed({{(SW - CH_W){chroma_i[CH_W-1]}}, chroma_i});
        if (csum < 0)
            comp_nxt = '0;
        else if (csum > $signed(SW'(2 ** YW - 1)))
            comp_nxt = '1;
        else
            comp_nxt = csum[YW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int j = 0; j < DEPTH; j++) ydl[j] <= '0;
            luma_o   <= '0;
            chroma_o <= '0;
            comp_o   <= '0;
        end else begin
            ydl[0] <= y_in;
            for (int j = 1; j < DEPTH; j++) ydl[j] <= ydl[j-1];
            luma_o   <= luma_nxt;
            chroma_o <= chroma_i;
            comp_o   <= comp_nxt;
        end
    end
endmodule

// File: rtl/chroma_mod_top.sv
module chroma_mod_top
    import cm_pkg::*;
#(
    parameter int AW = ACC_W,
    parameter int QW = QIDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     freq_word,
    input  logic [AW-1:0]     phase_ofs,
    input  logic              color_en,
    input  logic              burst_en,
    input  logic              pal_mode,
    input  logic [DLY_W-1:0]  luma_dly,
    input  logic              field_start,
    input  logic              line_start,
    input  logic              burst_win,
    input  logic [UV_W-1:0]   u_in,
    input  logic [UV_W-1:0]   v_in,
    input  logic [Y_W-1:0]    y_in,
    output logic [Y_W-1:0]    luma_o,
    output logic [CH_W-1:0]   chroma_o,
    output logic [Y_W-1:0]    comp_o
);
    localparam int PW = QW + 2;

    logic [PW-1:0] ph_idx;
    logic          line_odd;
    sin_t          sin_v, cos_v;
    ch_t           chroma_mod, chroma_out;

    cm_phase_acc #(.AW(AW), .PW(PW)) u_phase (
        .clk(clk), .rst(rst),
        .freq_word(freq_word), .phase_ofs(phase_ofs),
        .field_start(field_start), .line_start(line_start),
        .ph_idx(ph_idx), .line_odd(line_odd)
    );

    cm_sincos #(.QW(QW)) u_lut (
        .ph_idx(ph_idx), .sin_o(sin_v), .cos_o(cos_v)
    );

    cm_quad_mod u_mod (
        .clk(clk), .rst(rst),
        .sin_i(sin_v), .cos_i(cos_v),
        .u_i(uv_t'(u_in)), .v_i(uv_t'(v_in)),
        .burst_win(burst_win), .burst_en(burst_en),
        .color_en(color_en), .pal_mode(pal_mode),
        .line_odd(line_odd), .chroma_o(chroma_mod)
    );

    cm_luma_comp u_out (
        .clk(clk), .rst(rst),
        .y_in(y_in), .luma_dly(luma_dly),
        .chroma_i(chroma_mod),
        .luma_o(luma_o), .chroma_o(chroma_out), .comp_o(comp_o)
    );

    assign chroma_o = chroma_out;
endmodule

// File: rtl/cm_checker.sv
module cm_checker
    import cm_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             color_en,
    input logic             burst_en,
    input logic             burst_win,
    input logic [DLY_W-1:0] luma_dly,
    input logic [Y_W-1:0]   y_in,
    input logic [Y_W-1:0]   luma_o,
    input logic [CH_W-1:0]  chroma_o,
    input logic [Y_W-1:0]   comp_o
);
    logic [3:0] live_cnt;

    always_ff @(posedge clk) begin
        if (rst)
            live_cnt <= '0;
        else if (live_cnt != 4'hF)
            live_cnt <= live_cnt + 4'd1;
    end

    // R1: outputs cleared by reset
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (luma_o == '0 && chroma_o == '0 && comp_o == '0));

    // R5: colour removed outside the burst window
    assert_color_kill_R5: assert property (@(posedge clk) disable iff (rst)
        ($past(!color_en, 3) && $past(!burst_win, 3)) |-> chroma_o == '0);

    // R6: burst muted inside the window
    assert_burst_mute_R6: assert property (@(posedge clk) disable iff (rst)
        $past(burst_win && !burst_en, 3) |-> chroma_o == '0);

    // R8: shortest luma delay
    assert_luma_short_R8: assert property (@(posedge clk) disable iff (rst)
        (live_cnt >= 4'd6 && $past(luma_dly) <= 2'd1) |-> luma_o == $past(y_in, 4));

    // R9: composite equals luma when chroma is zero
    assert_comp_pass_R9: assert property (@(posedge clk) disable iff (rst)
        (chroma_o == '0) |-> comp_o == luma_o);
endmodule

bind chroma_mod_top cm_checker u_chk (
    .clk(clk), .rst(rst),
    .color_en(color_en), .burst_en(burst_en), .burst_win(burst_win),
    .luma_dly(luma_dly), .y_in(y_in),
    .luma_o(luma_o), .chroma_o(chroma_o), .comp_o(comp_o)
);

// File: tb/sim_chroma_mod_top.sv
module sim_chroma_mod_top;
    localparam int NMAX = 8192;
    localparam real TWO_PI = 6.283185307179586;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] freq_word = '0, phase_ofs = '0;
    logic        color_en = 1'b0, burst_en = 1'b0, pal_mode = 1'b0;
    logic [1:0]  luma_dly = 2'd1;
    logic        field_start = 1'b0, line_start = 1'b0, burst_win = 1'b0;
    logic [7:0]  u_in = '0, v_in = '0;
    logic [8:0]  y_in = '0;
    logic [8:0]  luma_o, comp_o;
    logic [8:0]  chroma_o;

    chroma_mod_top u0 (.*);

    always #5 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    int cyc = 0;
    int chexp [NMAX];
    int yrec  [NMAX];
    int drec  [NMAX];
    int obs_ch[NMAX];
    string ctag [NMAX];
    logic [31:0] m_acc = '0;
    bit          m_odd = 1'b0;
    logic [31:0] lcg = 32'h1234_5678;

    function automatic int ref_sin(input int n);
        return $rtoi($floor(255.0 * $sin(TWO_PI * (real'(n) + 0.5) / 256.0) + 0.5));
    endfunction

    function automatic int clamp9(input int x);
        return (x < 0) ? 0 : (x > 511) ? 511 : x;
    endfunction

    function automatic logic [31:0] next_rand(input logic [31:0] s);
        return s * 32'd1103515245 + 32'd12345;
    endfunction

    task automatic chk(input string tag, input int act, input int exp_v, input int e);
        n_chk++;
        if (act != exp_v) begin
            n_bad++;
            $display("FAIL %s edge %0d: actual %0d expected %0d", tag, e, act, exp_v);
        end
    endtask

    task automatic check_edge(input int e);
        int ec, d, li, el;
        ec = (e >= 2) ? chexp[e-2] : 0;
        d  = (drec[e] == 0) ? 1 : drec[e];
        li = e - 2 - d;
        el = (li >= 0) ? yrec[li] : 0;
        obs_ch[e] = int'($signed(chroma_o));
        chk((e >= 2) ? ctag[e-2] : "R1", int'($signed(chroma_o)), ec, e);
        chk("R8 luma delay", int'(luma_o), el, e);
        chk("R9 composite", int'(comp_o), clamp9(el + ec), e);
    endtask

    task automatic drive(input int c, input logic [31:0] fw, input logic [31:0] po,
                         input bit pal, input bit cen, input bit ben,
                         input bit fs, input bit ls, input bit bw,
                         input int u, input int v, input int y, input int d,
                         input string tag_active);
        logic [31:0] base, ph;
        int n, s, co, us, vs;
        freq_word = fw; phase_ofs = po; pal_mode = pal; color_en = cen; burst_en = ben;
        field_start = fs; line_start = ls; burst_win = bw;
        u_in = u[7:0]; v_in = v[7:0]; y_in = y[8:0]; luma_dly = d[1:0];
        base  = fs ? 32'd0 : m_acc;
        ph    = base + po;
        m_acc = base + fw;
        m_odd = fs ? 1'b0 : (ls ? ~m_odd : m_odd);
        n  = int'(ph[31:24]);
        s  = ref_sin(n);
        co = ref_sin((n + 64) % 256);
        if (bw) begin
            if (!ben) begin us = 0; vs = 0; ctag[c] = "R6 burst muted"; end
            else if (pal) begin us = -42; vs = m_odd ? -42 : 42; ctag[c] = "R7 alternating burst"; end
            else begin us = -60; vs = 0; ctag[c] = "R6 burst"; end
        end else if (!cen) begin
            us = 0; vs = 0; ctag[c] = "R5 colour removed";
        end else begin
            us = u; vs = v; ctag[c] = tag_active;
        end
        chexp[c] = (us * s + vs * co + 128) >>> 8;
        yrec[c]  = y;
        drec[c]  = d;
    endtask

    task automatic step_wait();
        if (cyc > 0) begin
            @(negedge clk);
            check_edge(cyc - 1);
        end
    endtask

    task automatic run_seg(input int n, input logic [31:0] fw, input logic [31:0] po,
                           input bit pal, input int lp, input bit cen, input bit ben,
                           input bit fixuv, input int fs_every, input string tag);
        for (int k = 0; k < n; k++) begin
            int u, v, y, d;
            bit fs, ls, bw;
            step_wait();
            lcg = next_rand(lcg);
            u = fixuv ? 100 : int'($signed(lcg[31:24]));
            v = fixuv ? -50 : int'($signed(lcg[23:16]));
            y = int'(lcg[15:7]);
            if (k % 7 == 3) y = 0;
            if (k % 11 == 5) y = 511;
            d = int'(lcg[5:4]);
            fs = (k == 0) || (fs_every > 0 && k % fs_every == 0);
            ls = (lp > 0) && (k % lp == 0);
            bw = (lp > 0) && (k % lp < 6);
            drive(cyc, fw, po, pal, cen, ben, fs, ls, bw, u, v, y, d, tag);
            cyc++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  %0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
        $finish;
    end

    initial begin
        int g0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset luma", int'(luma_o), 0, 0);
        chk("R1 reset chroma", int'(chroma_o), 0, 0);
        chk("R1 reset composite", int'(comp_o), 0, 0);
        rst = 1'b0;

        // fixed U/V, tuning word 2^28: phase repeats every 16 samples (R2)
        g0 = cyc;
        run_seg(48, 32'h1000_0000, 32'h0, 0, 0, 1, 1, 1, 0, "R2 phase accumulation");
        // 525-line burst, offset phase, random colour (R4, R6)
        run_seg(1500, 32'h21F0_7C1F, 32'h4000_0000, 0, 40, 1, 1, 0, 0, "R4 modulation");
        // alternating burst, field restart on a line start in the burst window (R7, R2)
        run_seg(1500, 32'h2A09_8ACB, 32'h9000_0000, 1, 30, 1, 1, 0, 120, "R2 restart with R4");
        // colour removed (R5)
        run_seg(600, 32'h21F0_7C1F, 32'h0, 1, 25, 0, 1, 0, 100, "R5 colour removed");
        // burst muted (R6)
        run_seg(600, 32'h21F0_7C1F, 32'h0, 0, 25, 1, 0, 0, 0, "R4 modulation");
        // one table step per sample: every index n visited (R3)
        run_seg(2048, 32'h0100_0000, 32'h0080_0000, 0, 0, 1, 1, 0, 0, "R3 sine and cosine");
        // flush
        run_seg(8, 32'h0, 32'h0, 0, 0, 0, 0, 0, 0, "R5 colour removed");
        @(negedge clk);
        check_edge(cyc - 1);

        for (int k = 0; k < 20; k++)
            chk("R2 wrap after 16 samples", obs_ch[g0 + k + 18], obs_ch[g0 + k + 2], g0 + k + 18);

        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule